// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the device-side command interpreter of a NOR-style parallel flash. It watches host write cycles, made of an address, a data value and a write strobe, and follows multi-write unlock sequences. These sequences move it between three resting behaviours: normal array reads, a signature mode in which reads return fixed identification values, and an internal chip erase. While the erase runs, and after it fails, every read returns a status byte in place of array data. The host polls that byte to see when the operation ends and whether it succeeded.

The storage array is a small register file of 16-bit words. The block can be read as 16-bit words or as 8-bit bytes, chosen by a mode input. The physical erase is replaced by a deterministic cycle schedule. First the array is cleared to zero one word per cycle, then it is set to all ones one word per cycle, and the operation completes after a parameterised number of cycles. A second parameter sets a time limit, and a test input can force the limit to trip.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the block is in array-read mode and word i holds 16'h3C00 + i. With word_mode=1 a read returns the word at rd_addr. With word_mode=0, rd_addr[0]=1 selects the high byte and rd_addr[0]=0 the low byte of word rd_addr>>1, returned in rd_data[7:0] with rd_data[15:8]=0.
- R2: Command addresses are compared on wr_addr[10:0] and command data on wr_data[7:0]. An unlock is 8'hAA written at 11'h555 followed by 8'h55 written at 11'h2AA. Any write that does not continue a partly entered sequence returns the block to array-read mode and is not taken as a command.
- R3: Writing 8'h90 at 11'h555 right after an unlock enters identifier mode. The mode persists across writes that neither start an unlock nor hold 8'hF0.
- R4: In identifier mode, rd_addr[1:0]=0 returns 16'h00C2 and rd_addr[1:0]=1 returns the device code: 16'h22D6 with BOTTOM_BOOT=0, 16'h2258 with BOTTOM_BOOT=1. With word_mode=0 only the low byte is returned, with rd_data[15:8]=0.
- R5: In identifier mode, rd_addr[1]=1 returns 16'h0001 when the sector rd_addr[IDX_W-1:IDX_W-2] has its PROT_MASK bit set, and 16'h0000 otherwise.
- R6: A write of 8'hF0 in any state other than a running erase returns the block to array-read mode. This includes the failed-erase state.
- R7: Chip erase starts at the clock edge that accepts the sixth write of the sequence unlock, 8'h80 at 11'h555, unlock, 8'h10 at 11'h555. Writes made while the erase runs, 8'hF0 included, are ignored.
- R8: While erasing or failed, rd_data is status: bit 7 = 0, bit 6 toggles after each read (0 on the first read after the start), bit 5 = failure flag, and all other bits 0.
- R9: In erase cycle c (c=0 at the first edge after the start), word c is cleared for c<DEPTH and word c-DEPTH is set to 16'hFFFF for DEPTH<=c<2*DEPTH. The erase ends at cycle max(ERASE_CYCLES,2*DEPTH)-1, after which every word reads 16'hFFFF in array-read mode.
- R10: If force_timeout is high in an erase cycle, or TIMEOUT_CYCLES cycles pass first, the block enters the failed state. In that cycle no word is written. The failed state reports status bit 5 = 1 and leaves only on 8'hF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_mode | input | 1 | 1: 16-bit reads, 0: 8-bit reads |
| wr_en | input | 1 | Host write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data, command in low byte |
| rd_en | input | 1 | Host read cycle (advances status toggle) |
| rd_addr | input | ADDR_W | Read address |
| force_timeout | input | 1 | Test input forcing the erase time limit |
| rd_data | output | 16 | Read data, combinational from rd_addr and state |

## Verification
Several properties are checked on every cycle. The status byte shape holds while busy, the toggle bit changes between back-to-back status reads, and the failed state stays put until 8'hF0 and shows bit 5. The 8'hF0 escape, the breaking of an unlock, the entry into erase and the forced failure all land in the right state. Only the bench scenarios show the stored data and the read mapping: the signature values per address and width, the protection bits per sector, the zero-then-ones order of the erase, the exact completion cycle and the all-ones array afterwards.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W = 12,
  parameter int DEPTH = 16,
  parameter int SECTORS = 4,
  parameter int ERASE_CYCLES = 40,
  parameter int TIMEOUT_CYCLES = 200,
  parameter bit BOTTOM_BOOT = 1'b0,
  parameter logic [SECTORS-1:0] PROT_MASK = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              force_timeout,
  output logic [15:0]       rd_data
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int END_CYC = (ERASE_CYCLES > 2*DEPTH) ? ERASE_CYCLES : 2*DEPTH;
  localparam int MAX_CYC = (END_CYC > TIMEOUT_CYCLES) ? END_CYC : TIMEOUT_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] END_LAST = CNT_W'(END_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [15:0] DEV_CODE = BOTTOM_BOOT ? 16'h2258 : 16'h22D6;

  typedef enum logic [3:0] {
    S_READ = 4'd0, S_UNLK1 = 4'd1, S_UNLK2 = 4'd2, S_SETUP = 4'd3,
    S_UNLK3 = 4'd4, S_UNLK4 = 4'd5, S_ID = 4'd6, S_ERASE = 4'd7, S_FAIL = 4'd8
  } state_t;

  state_t st, nxt;
  logic [CNT_W-1:0] cyc;
  logic tog;
  logic [15:0] mem [DEPTH];

  wire [7:0] cmd   = wr_data[7:0];
  wire is_f0       = cmd == 8'hF0;
  wire at_555      = wr_addr[10:0] == 11'h555;
  wire at_2aa      = wr_addr[10:0] == 11'h2AA;
  wire unlock_a    = at_555 && cmd == 8'hAA;
  wire unlock_b    = at_2aa && cmd == 8'h55;
  wire busy        = st == S_ERASE || st == S_FAIL;

  always_comb begin
    nxt = st;
    if (is_f0) nxt = S_READ;
    else begin
      case (st)
        S_READ:  nxt = unlock_a ? S_UNLK1 : S_READ;
        S_ID:    nxt = unlock_a ? S_UNLK1 : S_ID;
        S_UNLK1: nxt = unlock_b ? S_UNLK2 : S_READ;
        S_UNLK2: nxt = (at_555 && cmd == 8'h90) ? S_ID :
                       (at_555 && cmd == 8'h80) ? S_SETUP : S_READ;
        S_SETUP: nxt = unlock_a ? S_UNLK3 : S_READ;
        S_UNLK3: nxt = unlock_b ? S_UNLK4 : S_READ;
        S_UNLK4: nxt = (at_555 && cmd == 8'h10) ? S_ERASE : S_READ;
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_READ;
      cyc <= '0;
      tog <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'h3C00 + 16'(i);
    end else begin
      case (st)
        S_ERASE: begin
          if (rd_en) tog <= ~tog;
          if (force_timeout) st <= S_FAIL;
          else begin
            if (cyc[CNT_W-1:IDX_W] == '0) mem[cyc[IDX_W-1:0]] <= 16'h0000;
            else if (cyc[CNT_W-1:IDX_W+1] == '0) mem[cyc[IDX_W-1:0]] <= 16'hFFFF;
            if (cyc == END_LAST) st <= S_READ;
            else if (cyc == TMO_LAST) st <= S_FAIL;
            else cyc <= cyc + 1'b1;
          end
        end
        S_FAIL: begin
          if (rd_en) tog <= ~tog;
          if (wr_en && is_f0) st <= S_READ;
        end
        default: begin
          if (wr_en) begin
            st <= nxt;
            if (nxt == S_ERASE) begin
              cyc <= '0;
              tog <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  wire [IDX_W-1:0] idx = word_mode ? rd_addr[IDX_W-1:0] : rd_addr[IDX_W:1];
  wire [15:0] word_q   = mem[idx];
  wire [7:0]  byte_q   = rd_addr[0] ? word_q[15:8] : word_q[7:0];
  wire [SEC_W-1:0] sec = rd_addr[IDX_W-1 -: SEC_W];
  wire [15:0] id_q     = rd_addr[1] ? {15'd0, PROT_MASK[sec]} :
                         rd_addr[0] ? DEV_CODE : 16'h00C2;
  wire [15:0] status   = {8'h00, 1'b0, tog, st == S_FAIL, 5'b00000};

  assign rd_data = busy ? status :
                   (st == S_ID) ? (word_mode ? id_q : {8'h00, id_q[7:0]}) :
                   (word_mode ? word_q : {8'h00, byte_q});

  logic unused_bits;
  assign unused_bits = ^{wr_data[15:8], wr_addr[ADDR_W-1:11], rd_addr[ADDR_W-1:IDX_W+1]};
endmodule

module flash_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [10:0] wr_addr,
  input logic [7:0]  wr_byte,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        force_timeout,
  input logic [3:0]  st
);
  localparam logic [3:0] C_READ = 4'd0, C_UNLK1 = 4'd1, C_UNLK4 = 4'd5,
                         C_ID = 4'd6, C_ERASE = 4'd7, C_FAIL = 4'd8;
  wire busy = st == C_ERASE || st == C_FAIL;

  AST_F0_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte == 8'hF0 && st != C_ERASE) |=> st == C_READ); // R6
  AST_BREAK_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_UNLK1 && wr_en && !(wr_addr == 11'h2AA && wr_byte == 8'h55)) |=> st == C_READ); // R2
  AST_ERASE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_UNLK4 && wr_en && wr_addr == 11'h555 && wr_byte == 8'h10) |=> st == C_ERASE); // R7
  AST_ERASE_NO_WR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ERASE && wr_en && !force_timeout) |=> (st == C_ERASE || st == C_READ || st == C_FAIL)); // R7
  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data[15:7] == 9'd0 && rd_data[4:0] == 5'd0)); // R8
  AST_Q6_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (!(st == C_ERASE || st == C_FAIL) || rd_data[6] != $past(rd_data[6]))); // R8
  AST_FAIL_Q5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_FAIL) |-> rd_data[5]); // R10
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_FAIL && !(wr_en && wr_byte == 8'hF0)) |=> st == C_FAIL); // R10
  AST_FORCE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ERASE && force_timeout) |=> st == C_FAIL); // R10
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ID && !wr_en) |=> st == C_ID); // R3
endmodule

bind flash_cmd_fsm flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr[10:0]),
  .wr_byte(wr_data[7:0]), .rd_en(rd_en), .rd_data(rd_data),
  .force_timeout(force_timeout), .st(st)
);

// File: tb/tb_flash_cmd_fsm.sv
module tb_flash_cmd_fsm;
  localparam int DEPTH = 16;
  localparam int ERASE_CYCLES = 40;
  localparam int END_CYC = (ERASE_CYCLES > 2*DEPTH) ? ERASE_CYCLES : 2*DEPTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_mode = 1'b1;
  logic wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic force_timeout = 1'b0;
  logic [15:0] rd_data, rd_data_bot;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic tog_m;

  always #10 clk = ~clk;

  flash_cmd_fsm #(.DEPTH(DEPTH), .ERASE_CYCLES(ERASE_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .force_timeout(force_timeout),
    .rd_data(rd_data));

  flash_cmd_fsm #(.DEPTH(DEPTH), .ERASE_CYCLES(ERASE_CYCLES), .BOTTOM_BOOT(1'b1)) dut_bot (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .force_timeout(force_timeout),
    .rd_data(rd_data_bot));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055);
  endtask

  task automatic erase_seq();
    unlock();
    wr(12'h555, 16'h0080);
    unlock();
    wr(12'h555, 16'h0010);
  endtask

  always begin
    @(negedge clk);
    #2;
    if (rd_en) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset contents and width selection
    rd(12'h005, 16'h3C05, "R1 word read");
    word_mode = 1'b0;
    rd(12'h005, 16'h003C, "R1 byte high");
    rd(12'h004, 16'h0002, "R1 byte low");
    word_mode = 1'b1;

    // R3/R4/R5 identifier mode
    unlock();
    wr(12'h555, 16'h0090);
    rd(12'h000, 16'h00C2, "R4 manufacturer word");
    rd(12'h001, 16'h22D6, "R4 device word");
    rd_addr = 12'h001; #2;
    check("R4 bottom variant", rd_data_bot, 16'h2258);
    @(negedge clk);
    rd(12'h002, 16'h0001, "R5 sector0 protected");
    rd(12'h006, 16'h0000, "R5 sector1 open");
    rd(12'h00A, 16'h0001, "R5 sector2 protected");
    rd(12'h00F, 16'h0000, "R5 sector3 open");
    word_mode = 1'b0;
    rd(12'h001, 16'h00D6, "R4 device byte");
    word_mode = 1'b1;
    wr(12'h000, 16'h0012);
    rd(12'h000, 16'h00C2, "R3 id persists");

    // R2 broken unlock from identifier mode
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0011);
    rd(12'h000, 16'h3C00, "R2 break from id");
    wr(12'h555, 16'h00AA);
    wr(12'h123, 16'h0055);
    wr(12'h555, 16'h0090);
    rd(12'h000, 16'h3C00, "R2 wrong address");
    unlock();
    wr(12'h555, 16'h0077);
    wr(12'h555, 16'h0090);
    rd(12'h001, 16'h3C01, "R2 bad command");

    // R6 escape from identifier mode
    unlock();
    wr(12'h555, 16'h0090);
    wr(12'h000, 16'h00F0);
    rd(12'h003, 16'h3C03, "R6 F0 to read");

    // R7/R8/R9 full erase
    erase_seq();
    tog_m = 1'b0;
    for (int j = 0; j < END_CYC; j++) begin
      if (j == 5) wr(12'h000, 16'h00F0);
      else begin
        rd(12'h000, {9'd0, tog_m, 6'd0}, "R8 erase status");
        tog_m = ~tog_m;
      end
    end
    rd(12'h003, 16'hFFFF, "R9 completes on time");
    for (int i = 0; i < DEPTH; i++) rd(12'(i), 16'hFFFF, "R9 all ones");
    word_mode = 1'b0;
    rd(12'h007, 16'h00FF, "R9 byte after erase");
    word_mode = 1'b1;

    // R10 forced failure
    erase_seq();
    tog_m = 1'b0;
    for (int j = 0; j < 4; j++) begin
      force_timeout = (j == 3);
      rd(12'h000, {9'd0, tog_m, 6'd0}, "R8 status before fail");
      tog_m = ~tog_m;
    end
    force_timeout = 1'b0;
    rd(12'h000, {9'd0, tog_m, 1'b1, 5'd0}, "R10 fail flag");
    tog_m = ~tog_m;
    wr(12'h555, 16'h00AA);
    rd(12'h000, {9'd0, tog_m, 1'b1, 5'd0}, "R10 fail holds");
    wr(12'h000, 16'h00F0);
    rd(12'h000, 16'h0000, "R9 word0 cleared first");
    rd(12'h002, 16'h0000, "R9 word2 cleared first");
    rd(12'h003, 16'hFFFF, "R10 no write in fail cycle");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule